// File: doc/BRIEF.md
# Parallel Signature and Up-Count Test Engine

This block is a boundary-scan style test engine for an 18-bit two-sided bus. On every rising test-clock edge it folds the word sampled on one bus side into a parallel-input signature register. On the same edge it advances a binary up-counter whose value is driven onto the opposite side. The counter reaches the pins through shadow latches that take a new value only on the falling edge. That way the driven pattern settles half a cycle after the count step and never moves on the rising edge, where the other side is being sampled.

Both registers form one 36-bit serial chain. Test software shifts a seed in through this chain before a run and shifts the signature and count out after it. A direction select chooses which side is compressed and which side is driven. The side not being driven reads back as all zeros.

Top module: `sigcount_engine`

## Requirements
- R1: An asynchronous active-low reset (`trst_n` low) clears the signature, the counter and the shadow latches at once. Both drive buses and `scan_out` then read zero.
- R2: On a rising edge with `run_en`=1 and `shift_en`=0, the signature becomes its old value shifted one place toward the MSB with a zero entering bit 0. When the old bit 17 was 1, bits 0 and 7 are then inverted (polynomial x^18+x^7+1). The result is then XORed bitwise with the sampled word.
- R3: On the same rising edge the counter increases by one.
- R4: The counter wraps from 0x3FFFF to 0x00000.
- R5: The driven bus changes only at a falling edge. After the falling edge that follows a count step, it shows the counter value produced by that step.
- R6: With `dir_sel`=0, `a_pins_in` is compressed, `b_pins_out` carries the shadow value and `a_pins_out` is zero. With `dir_sel`=1, `b_pins_in` is compressed, `a_pins_out` carries the shadow value and `b_pins_out` is zero.
- R7: While `shift_en`=1, each rising edge shifts the 36-bit chain one place. `scan_in` enters signature bit 17, signature bit 0 feeds counter bit 17, and `scan_out` shows counter bit 0. The first bit shifted in ends up in counter bit 0, and bit 18 of the sequence ends up in signature bit 0. `shift_en` takes priority over `run_en`.
- R8: With `run_en`=0 and `shift_en`=0, the signature, the counter and the driven bus keep their values whatever the sampled buses carry.
- R9: During scan shifting no compression or counting takes place, and the shadow latches and driven bus hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run strobe: compress and count on this rising edge |
| shift_en | input | 1 | Serial scan mode for the 36-bit chain |
| scan_in | input | 1 | Serial data into signature bit 17 |
| dir_sel | input | 1 | 0: A sampled, B driven; 1: B sampled, A driven |
| a_pins_in | input | 18 | Sampled value of the A side |
| b_pins_in | input | 18 | Sampled value of the B side |
| scan_out | output | 1 | Serial data from counter bit 0 |
| a_pins_out | output | 18 | Drive value for the A side |
| b_pins_out | output | 18 | Drive value for the B side |

## Verification
The signature is exercised from a seed with an all-zero input stream, which isolates the feedback taps. A walking one then checks that every input bit enters at its own position. Alternating 0x2AAAA/0x15555 words catch adjacent-bit swaps, and a dense arithmetic stream sampled from the B side shows that the direction select picks the right side while the other side carries unrelated data. The count runs through the wrap point. The drive bus is compared at every falling edge against queued expected values and at every rising edge for unwanted movement, which separates correct half-cycle staging from a latch that follows the count early or late.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int unsigned SCE_W_DEF = 18;
  localparam logic [17:0] SCE_POLY_DEF = 18'h00081;

  typedef enum logic {
    SIDE_A_SAMPLED = 1'b0,
    SIDE_B_SAMPLED = 1'b1
  } sce_dir_e;
endpackage

// File: rtl/sce_sig_reg.sv
module sce_sig_reg #(
  parameter int unsigned W = 18,
  parameter logic [W-1:0] POLY = 18'h00081
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         step,
  input  logic         shift,
  input  logic         ser_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig_q
);
  function automatic logic [W-1:0] lfsr_fold(input logic [W-1:0] s, input logic [W-1:0] d);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ d;
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    sig_q <= '0;
    else if (shift) sig_q <= {ser_in, sig_q[W-1:1]};
    else if (step)  sig_q <= lfsr_fold(sig_q, din);
  end
endmodule

// File: rtl/sce_counter.sv
module sce_counter #(
  parameter int unsigned W = 18
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         step,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] cnt_q
);
  function automatic logic [W-1:0] count_up(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    cnt_q <= '0;
    else if (shift) cnt_q <= {ser_in, cnt_q[W-1:1]};
    else if (step)  cnt_q <= count_up(cnt_q);
  end
endmodule

// File: rtl/sce_shadow.sv
module sce_shadow #(
  parameter int unsigned W = 18
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         step,
  input  logic [W-1:0] cnt,
  output logic         upd_pend,
  output logic [W-1:0] shadow_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) upd_pend <= 1'b0;
    else         upd_pend <= step;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)       shadow_q <= '0;
    else if (upd_pend) shadow_q <= cnt;
  end
endmodule

// File: rtl/sigcount_engine.sv
module sigcount_engine #(
  parameter int unsigned W = sce_pkg::SCE_W_DEF,
  parameter logic [W-1:0] POLY = W'(sce_pkg::SCE_POLY_DEF)
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         run_en,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic         dir_sel,
  input  logic [W-1:0] a_pins_in,
  input  logic [W-1:0] b_pins_in,
  output logic         scan_out,
  output logic [W-1:0] a_pins_out,
  output logic [W-1:0] b_pins_out
);
  import sce_pkg::*;

  sce_dir_e     dir;
  logic         run_step;
  logic         upd_pend;
  logic [W-1:0] sample_bus;
  logic [W-1:0] sig_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] shadow_q;

  assign dir        = sce_dir_e'(dir_sel);
  assign run_step   = run_en & ~shift_en;
  assign sample_bus = (dir == SIDE_B_SAMPLED) ? b_pins_in : a_pins_in;

  sce_sig_reg #(.W(W), .POLY(POLY)) u_sig (
    .tck(tck), .trst_n(trst_n), .step(run_step), .shift(shift_en),
    .ser_in(scan_in), .din(sample_bus), .sig_q(sig_q)
  );

  sce_counter #(.W(W)) u_cnt (
    .tck(tck), .trst_n(trst_n), .step(run_step), .shift(shift_en),
    .ser_in(sig_q[0]), .cnt_q(cnt_q)
  );

  sce_shadow #(.W(W)) u_shadow (
    .tck(tck), .trst_n(trst_n), .step(run_step), .cnt(cnt_q),
    .upd_pend(upd_pend), .shadow_q(shadow_q)
  );

  assign scan_out   = cnt_q[0];
  assign a_pins_out = (dir == SIDE_B_SAMPLED) ? shadow_q : '0;
  assign b_pins_out = (dir == SIDE_A_SAMPLED) ? shadow_q : '0;
endmodule

// File: rtl/sigcount_engine_chk.sv
module sigcount_engine_chk #(
  parameter int unsigned W = 18
) (
  input logic         tck,
  input logic         trst_n,
  input logic         run_en,
  input logic         shift_en,
  input logic         scan_in,
  input logic         run_step,
  input logic [W-1:0] sig_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] shadow_q
);
  // R3
  count_step_chk: assert property (@(posedge tck) disable iff (!trst_n)
    run_step |=> cnt_q == $past(cnt_q) + W'(1));

  // R5
  shadow_follow_chk: assert property (@(posedge tck) disable iff (!trst_n)
    run_step |=> shadow_q == cnt_q);

  // R8
  idle_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!run_en && !shift_en) |=> ($stable(sig_q) && $stable(cnt_q) && $stable(shadow_q)));

  // R7
  scan_chain_chk: assert property (@(posedge tck) disable iff (!trst_n)
    shift_en |=> (sig_q[W-1] == $past(scan_in)) && (cnt_q[W-1] == $past(sig_q[0])));

  // R9
  scan_no_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    shift_en |=> $stable(shadow_q));
endmodule

bind sigcount_engine sigcount_engine_chk #(.W(W)) u_chk (
  .tck(tck), .trst_n(trst_n), .run_en(run_en), .shift_en(shift_en),
  .scan_in(scan_in), .run_step(run_step), .sig_q(sig_q), .cnt_q(cnt_q),
  .shadow_q(shadow_q)
);

// File: tb/sigcount_engine_bench.sv
module sigcount_engine_bench;
  localparam int W = 18;

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         run_en = 1'b0;
  logic         shift_en = 1'b0;
  logic         scan_in = 1'b0;
  logic         dir_sel = 1'b0;
  logic [W-1:0] a_pins_in = '0;
  logic [W-1:0] b_pins_in = '0;
  logic         scan_out;
  logic [W-1:0] a_pins_out;
  logic [W-1:0] b_pins_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit mon_on = 0;

  typedef struct {
    logic [W-1:0] val;
    logic         dir;
    string        req;
  } exp_item_t;
  exp_item_t exp_q[$];

  logic [W-1:0] m_sig = '0;
  logic [W-1:0] m_cnt = '0;
  logic [2*W-1:0] last_pair = '0;

  always #4 tck = ~tck;

  sigcount_engine u_sigcount_engine (
    .tck(tck), .trst_n(trst_n), .run_en(run_en), .shift_en(shift_en),
    .scan_in(scan_in), .dir_sel(dir_sel), .a_pins_in(a_pins_in),
    .b_pins_in(b_pins_in), .scan_out(scan_out), .a_pins_out(a_pins_out),
    .b_pins_out(b_pins_out)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ref_sig(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] r;
    r = s << 1;
    if (s[W-1]) begin
      r[0] = ~r[0];
      r[7] = ~r[7];
    end
    return r ^ d;
  endfunction

  task automatic step_clk;
    @(posedge tck);
    #2;
  endtask

  task automatic scan36(input logic [2*W-1:0] load, input string req);
    logic [2*W-1:0] got;
    logic [2*W-1:0] want;
    want = {m_sig, m_cnt};
    run_en = 1'b0;
    shift_en = 1'b1;
    for (int i = 0; i < 2*W; i++) begin
      scan_in = load[i];
      got[i] = scan_out;
      step_clk();
    end
    shift_en = 1'b0;
    check(got[W-1:0] == want[W-1:0], {req, " R7 R9 count readout"}, 64'(got[W-1:0]), 64'(want[W-1:0]));
    check(got[2*W-1:W] == want[2*W-1:W], {req, " R7 signature readout"}, 64'(got[2*W-1:W]), 64'(want[2*W-1:W]));
    m_cnt = load[W-1:0];
    m_sig = load[2*W-1:W];
  endtask

  task automatic run_one(input logic dir, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    exp_item_t it;
    dir_sel = dir;
    a_pins_in = a;
    b_pins_in = b;
    run_en = 1'b1;
    shift_en = 1'b0;
    @(posedge tck);
    m_sig = ref_sig(m_sig, dir ? b : a);
    m_cnt = m_cnt + 1;
    it.val = m_cnt;
    it.dir = dir;
    it.req = req;
    exp_q.push_back(it);
    #2;
    run_en = 1'b0;
  endtask

  // scoreboard monitor: falling edge pops expected drive values
  always @(negedge tck) begin
    #1;
    last_pair = {a_pins_out, b_pins_out};
    if (exp_q.size() > 0) begin
      exp_item_t it;
      it = exp_q.pop_front();
      if (it.dir) begin
        check(a_pins_out == it.val, {it.req, " R5 R6 A drive"}, 64'(a_pins_out), 64'(it.val));
        check(b_pins_out == '0, "R6 B idle", 64'(b_pins_out), 64'(0));
      end else begin
        check(b_pins_out == it.val, {it.req, " R5 R6 B drive"}, 64'(b_pins_out), 64'(it.val));
        check(a_pins_out == '0, "R6 A idle", 64'(a_pins_out), 64'(0));
      end
    end
  end

  // rising-edge monitor: drive buses must not move at the rising edge (R5)
  always @(posedge tck) begin
    #1;
    if (mon_on && trst_n)
      check({a_pins_out, b_pins_out} == last_pair, "R5 no rising-edge change",
            64'({a_pins_out, b_pins_out}), 64'(last_pair));
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #10;
    check(scan_out == 1'b0 && a_pins_out == '0 && b_pins_out == '0, "R1 reset outputs",
          64'({scan_out, a_pins_out, b_pins_out}), 64'(0));
    @(posedge tck);
    #2;
    trst_n = 1'b1;
    step_clk();
    mon_on = 1'b1;
    scan36({18'h00001, 18'h00000}, "R1 reset scan");

    // R2: pure feedback, zero input
    for (int i = 0; i < 40; i++) run_one(1'b0, '0, 18'h3FFFF, "R2 zero stream");
    step_clk();
    scan36({18'h20000, 18'h00100}, "R2 zero stream");

    // R2: walking one on A
    for (int i = 0; i < W; i++) run_one(1'b0, 18'(1) << i, 18'h2AAAA, "R2 walking one");
    step_clk();
    scan36({18'h0F0F0, 18'h00010}, "R2 walking one");

    // R2: alternating pattern
    for (int i = 0; i < 12; i++) run_one(1'b0, (i % 2) ? 18'h15555 : 18'h2AAAA, 18'h0, "R2 alternating");
    step_clk();
    scan36({18'h12345, 18'h00200}, "R2 alternating");

    // R6: B side sampled, A side driven
    for (int i = 0; i < 20; i++) run_one(1'b1, 18'h3FFFF ^ 18'(i), 18'(i * 18'h01357), "R6 B sampled");
    step_clk();
    scan36({18'h00ABC, 18'h3FFFE}, "R6 B sampled");

    // R4: wrap
    for (int i = 0; i < 3; i++) run_one(1'b0, 18'(i), 18'h0, "R4 wrap");
    step_clk();
    check(b_pins_out == 18'h00001, "R4 after wrap", 64'(b_pins_out), 64'(1));
    scan36({18'h11111, 18'h00050}, "R4 wrap");

    // R8: idle with changing inputs
    run_one(1'b0, 18'h00777, 18'h0, "R8 setup");
    step_clk();
    for (int i = 0; i < 5; i++) begin
      a_pins_in = 18'(i * 18'h0ABCD);
      b_pins_in = ~a_pins_in;
      step_clk();
    end
    check(b_pins_out == 18'h00051, "R8 drive held", 64'(b_pins_out), 64'(18'h00051));
    scan36({18'h00000, 18'h00000}, "R8 idle hold");

    // R9: shadow unchanged across a whole scan
    check(b_pins_out == 18'h00051, "R9 drive held during scan", 64'(b_pins_out), 64'(18'h00051));

    // R1: asynchronous reset mid-run
    run_one(1'b0, 18'h00003, 18'h0, "R1 setup");
    step_clk();
    mon_on = 1'b0;
    trst_n = 1'b0;
    #1;
    check(scan_out == 1'b0 && b_pins_out == '0 && a_pins_out == '0, "R1 async clear",
          64'({scan_out, a_pins_out, b_pins_out}), 64'(0));
    m_sig = '0;
    m_cnt = '0;
    step_clk();
    trst_n = 1'b1;
    step_clk();
    mon_on = 1'b1;
    scan36({18'h0, 18'h0}, "R1 after async reset");

    step_clk();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule